// File: doc/BRIEF.md
# Ordered Store Queue with Load Bypass and Fence

This block sits between a single core's memory port and a shared memory. Stores from the core go into a small first-in first-out queue and are accepted at once. The queue then writes them out to shared memory one at a time, in the order it received them, each write using a valid/ready handshake. Shared memory and every other agent see a store only on the cycle its write is accepted.

Loads do not wait for queued stores to drain. If the queue holds a store to the load's address, the load takes the data of the most recent such store. Otherwise the load goes to shared memory on its own read handshake. As a result, the only ordering that other agents can observe out of program order is an older store becoming visible after a younger load.

A fence request holds off all further core traffic until the queue is empty, which makes every earlier store visible first. A synchronous reset throws away all queued stores.

Top module: `tso_store_buffer`

## Requirements
- R1: Queued stores are written to shared memory strictly in the order the core issued them. While the queue is non-empty, `mem_wr_valid` is high and `mem_wr_addr`/`mem_wr_data` show the oldest entry.
- R2: A store changes shared memory only on a cycle with `mem_wr_valid` and `mem_wr_ready` both high, and that entry leaves the queue on the same cycle. Before that cycle, a read of that address from shared memory returns the previous value.
- R3: The queue holds 8 entries. `st_ready` is low whenever the queue is full or `fence_req` is high. A store is accepted on a cycle with `st_valid` and `st_ready` both high.
- R4: While `mem_wr_valid` is high and `mem_wr_ready` is low, the head address and data stay unchanged on the next cycle.
- R5: A load whose address matches one or more queued entries is accepted at once, without waiting for the queue to drain, and it returns the data of the youngest matching entry.
- R6: A load with no matching entry raises `mem_rd_valid` with `mem_rd_addr` set to the load address, and it is accepted when `mem_rd_ready` is high. Every accepted load, whether it hit or missed, raises `ld_rvalid` on the next cycle. On a miss, `ld_rdata` then passes through `mem_rd_data` from that cycle; on a hit, it gives the data forwarded from the queue.
- R7: While `fence_req` is high and the queue is non-empty, `st_ready` and `ld_ready` are both low.
- R8: `fence_done` is high exactly when `fence_req` is high and the queue is empty. This includes the very cycle of the request if the queue is already empty.
- R9: If `st_valid` and `ld_valid` are both high in the same cycle, the store is treated as older. `ld_ready` is low and no read is issued that cycle.
- R10: Synchronous active-high `rst` empties the queue and discards all queued stores, and it clears `ld_rvalid`. After reset, `mem_wr_valid` is low and `st_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Core store request |
| st_addr | input | 16 | Store address |
| st_data | input | 32 | Store data |
| st_ready | output | 1 | Store accepted when high with st_valid |
| ld_valid | input | 1 | Core load request |
| ld_addr | input | 16 | Load address |
| ld_ready | output | 1 | Load accepted when high with ld_valid |
| ld_rvalid | output | 1 | Load result valid, one cycle after acceptance |
| ld_rdata | output | 32 | Load result data |
| fence_req | input | 1 | Fence request, held until fence_done |
| fence_done | output | 1 | Fence complete: queue empty |
| mem_wr_valid | output | 1 | Head store offered to shared memory |
| mem_wr_ready | input | 1 | Shared memory accepts the head store |
| mem_wr_addr | output | 16 | Head store address |
| mem_wr_data | output | 32 | Head store data |
| mem_rd_valid | output | 1 | Load miss read request |
| mem_rd_ready | input | 1 | Shared memory accepts the read |
| mem_rd_addr | output | 16 | Read address |
| mem_rd_data | input | 32 | Read data, valid the cycle after acceptance |

## Verification
The first pattern is a store burst with the write grant held low. It fills the queue and then pushes against the full condition, which separates correct back-pressure from an overflow that overwrites an entry. Loads to a narrow address range while several stores to the same address are queued separate youngest-match forwarding from oldest-match forwarding and from reads that fetch stale memory. Long random mixes with different grant rates, with stores and loads arriving in the same cycle, test drain order and the rule that the store goes first. Fences issued on an empty queue, on a full queue with a slow drain, and a reset with stores still queued separate the same-cycle completion, the stall and the discard from their wrong variants.

// File: rtl/tso_store_buffer.sv
module tso_store_buffer #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  output logic          st_ready,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  output logic          ld_ready,
  output logic          ld_rvalid,
  output logic [DW-1:0] ld_rdata,
  input  logic          fence_req,
  output logic          fence_done,
  output logic          mem_wr_valid,
  input  logic          mem_wr_ready,
  output logic [AW-1:0] mem_wr_addr,
  output logic [DW-1:0] mem_wr_data,
  output logic          mem_rd_valid,
  input  logic          mem_rd_ready,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [DW-1:0] mem_rd_data
);
  // DEPTH must be a power of two so the pointers wrap on their own.
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr, idx;
  logic [CW-1:0] count;
  logic          hit, fwd_q, push, pop;
  logic [DW-1:0] fwd, fwd_data;

  always_comb begin
    hit = 1'b0;
    fwd = '0;
    idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      idx = rd_ptr + PW'(i);
      if (CW'(i) < count && addr_q[idx] == ld_addr) begin
        hit = 1'b1;
        fwd = data_q[idx];
      end
    end
  end

  assign st_ready     = !fence_req && (count != CW'(DEPTH));
  assign ld_ready     = !fence_req && !st_valid && (hit || mem_rd_ready);
  assign mem_rd_valid = ld_valid && !fence_req && !st_valid && !hit;
  assign mem_rd_addr  = ld_addr;
  assign fence_done   = fence_req && (count == '0);
  assign mem_wr_valid = (count != '0);
  assign mem_wr_addr  = addr_q[rd_ptr];
  assign mem_wr_data  = data_q[rd_ptr];
  assign ld_rdata     = fwd_q ? fwd_data : mem_rd_data;
  assign push         = st_valid && st_ready;
  assign pop          = mem_wr_valid && mem_wr_ready;

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[wr_ptr] <= st_addr;
      data_q[wr_ptr] <= st_data;
    end
    fwd_data <= fwd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr    <= '0;
      wr_ptr    <= '0;
      count     <= '0;
      ld_rvalid <= 1'b0;
      fwd_q     <= 1'b0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      count     <= count + CW'(push) - CW'(pop);
      ld_rvalid <= ld_valid && ld_ready;
      fwd_q     <= hit;
    end
  end
endmodule

// File: rtl/tso_store_buffer_chk.sv
module tso_store_buffer_chk #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          st_valid,
  input logic          st_ready,
  input logic          ld_valid,
  input logic          ld_ready,
  input logic          ld_rvalid,
  input logic          fence_req,
  input logic          fence_done,
  input logic          mem_wr_valid,
  input logic          mem_wr_ready,
  input logic [AW-1:0] mem_wr_addr,
  input logic [DW-1:0] mem_wr_data,
  input logic [CW-1:0] count
);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (count == CW'(DEPTH)) |-> !st_ready);

  assert_head_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_valid && !mem_wr_ready) |=>
      (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  assert_load_resp_R6: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && ld_ready) |=> ld_rvalid);

  assert_fence_stall_R7: assert property (@(posedge clk) disable iff (rst)
    (fence_req && !fence_done) |-> (!st_ready && !ld_ready));

  assert_fence_empty_R8: assert property (@(posedge clk) disable iff (rst)
    fence_done |-> !mem_wr_valid);

  assert_store_first_R9: assert property (@(posedge clk) disable iff (rst)
    st_valid |-> !ld_ready);

  assert_reset_clear_R10: assert property (@(posedge clk)
    $past(rst) |-> (!mem_wr_valid && !ld_rvalid));
endmodule

bind tso_store_buffer tso_store_buffer_chk #(
  .AW(AW), .DW(DW), .DEPTH(DEPTH), .CW(CW)
) chk_i (
  .clk(clk), .rst(rst), .st_valid(st_valid), .st_ready(st_ready),
  .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_rvalid(ld_rvalid),
  .fence_req(fence_req), .fence_done(fence_done),
  .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
  .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .count(count)
);

// File: tb/tso_store_buffer_tb.sv
module tso_store_buffer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        st_valid = 0, ld_valid = 0, fence_req = 0;
  logic [15:0] st_addr = 0, ld_addr = 0;
  logic [31:0] st_data = 0, mem_rd_data = 0;
  logic        mem_wr_ready = 0, mem_rd_ready = 0;
  logic        st_ready, ld_ready, ld_rvalid, fence_done;
  logic        mem_wr_valid, mem_rd_valid;
  logic [15:0] mem_wr_addr, mem_rd_addr;
  logic [31:0] ld_rdata, mem_wr_data;

  tso_store_buffer dut_i (.*);

  always #5 clk = ~clk;

  int vectors = 0, fails = 0;
  bit done = 0;

  logic [15:0] qa[$];
  logic [31:0] qd[$];
  logic [31:0] mem [256];
  bit          pend_rv = 0;
  logic [31:0] pend_data = 0;
  bit          fence_hold = 0;
  int p_st, p_ld, p_wr, p_rd, p_fence;
  logic [15:0] amask;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    bit e_st_ready, e_ld_ready, e_mrv, e_fd, e_mwv, hit, n_rv;
    logic [31:0] fwd, n_data;
    @(negedge clk);
    st_valid     = !rst && ($urandom % 100) < p_st;
    st_addr      = 16'($urandom) & amask;
    st_data      = $urandom;
    ld_valid     = !rst && ($urandom % 100) < p_ld;
    ld_addr      = 16'($urandom) & amask;
    mem_wr_ready = ($urandom % 100) < p_wr;
    mem_rd_ready = ($urandom % 100) < p_rd;
    if (!rst && !fence_hold && ($urandom % 1000) < p_fence) fence_hold = 1;
    fence_req = fence_hold;
    #1;
    hit = 0; fwd = 0;
    foreach (qa[i]) if (qa[i] == ld_addr) begin hit = 1; fwd = qd[i]; end
    e_st_ready = !fence_req && qa.size() < 8;
    e_ld_ready = !fence_req && !st_valid && (hit || mem_rd_ready);
    e_mrv      = ld_valid && !fence_req && !st_valid && !hit;
    e_fd       = fence_req && qa.size() == 0;
    e_mwv      = qa.size() > 0;
    if (!rst) begin
      chk("R3/R7 st_ready", 32'(st_ready), 32'(e_st_ready));
      chk("R5/R7/R9 ld_ready", 32'(ld_ready), 32'(e_ld_ready));
      chk("R6/R9 mem_rd_valid", 32'(mem_rd_valid), 32'(e_mrv));
      if (e_mrv) chk("R6 mem_rd_addr", 32'(mem_rd_addr), 32'(ld_addr));
      chk("R8 fence_done", 32'(fence_done), 32'(e_fd));
      chk("R1/R2 mem_wr_valid", 32'(mem_wr_valid), 32'(e_mwv));
      if (e_mwv) begin
        chk("R1/R4 mem_wr_addr", 32'(mem_wr_addr), 32'(qa[0]));
        chk("R1/R4 mem_wr_data", mem_wr_data, qd[0]);
      end
      chk("R6 ld_rvalid", 32'(ld_rvalid), 32'(pend_rv));
      if (pend_rv) chk("R2/R5/R6 ld_rdata", ld_rdata, pend_data);
    end
    n_rv   = ld_valid && e_ld_ready;
    n_data = hit ? fwd : mem[ld_addr[7:0]];
    @(posedge clk); #1;
    mem_rd_data = $urandom;
    if (rst) begin
      qa.delete(); qd.delete(); pend_rv = 0; fence_hold = 0;
    end else begin
      if (e_mwv && mem_wr_ready) begin
        mem[qa[0][7:0]] = qd[0];
        void'(qa.pop_front()); void'(qd.pop_front());
      end
      if (st_valid && e_st_ready) begin qa.push_back(st_addr); qd.push_back(st_data); end
      pend_rv = n_rv; pend_data = n_data;
      if (n_rv && !hit) mem_rd_data = n_data;
      if (e_fd) fence_hold = 0;
    end
  endtask

  task automatic run(int n, int s, int l, int w, int r, int f, logic [15:0] m);
    p_st = s; p_ld = l; p_wr = w; p_rd = r; p_fence = f; amask = m;
    repeat (n) step();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hA5A50000 ^ (i * 32'h01010101);
    rst = 1;
    run(3, 0, 0, 50, 50, 0, 16'h7);
    @(negedge clk); rst = 0;
    #1;
    chk("R10 reset mem_wr_valid", 32'(mem_wr_valid), 0);
    chk("R10 reset st_ready", 32'(st_ready), 1);
    chk("R10 reset ld_rvalid", 32'(ld_rvalid), 0);
    // R8: fence on an empty queue completes in the same cycle
    fence_hold = 1;
    run(2, 0, 0, 100, 100, 0, 16'h7);
    // R3: fill with no write grant, push against full
    run(20, 100, 0, 0, 100, 0, 16'h3);
    // R5: loads with several matches queued, no drain
    run(30, 0, 100, 0, 50, 0, 16'h3);
    // R7: fence against a full queue with slow drain
    fence_hold = 1;
    run(60, 80, 80, 10, 50, 0, 16'h3);
    // R1/R2/R9: random mixes
    run(1500, 50, 50, 50, 50, 5, 16'h7);
    run(1500, 70, 40, 20, 80, 10, 16'h3);
    run(800, 30, 70, 90, 30, 20, 16'hF);
    // R10: reset with stores queued, then loads see old memory
    run(20, 100, 0, 0, 100, 0, 16'h7);
    rst = 1;
    run(2, 0, 0, 0, 100, 0, 16'h7);
    rst = 0;
    run(40, 0, 100, 100, 100, 0, 16'h7);
    run(500, 60, 60, 40, 60, 10, 16'h7);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule